// File: doc/BRIEF.md
# Power-Up Operating Mode Detection Sequencer

This block decides once per power-up whether a two-rail buck controller is strapped for independent dual-channel regulation or for two-phase operation with a shared output. The decision is made by reading a single multi-purpose pin. While a timed sampling window is open, the block loads that pin with a weak internal pull-down. At the end of the window a threshold comparator on the pin is sampled. A pin held near the supply rail by an external strap selects dual-channel mode. A pin that the weak load pulls down selects two-phase mode.

After detection the same pin changes role. In dual-channel mode it is released to high impedance. In two-phase mode it becomes the gate drive of an external switch that ties the two output rails together. The block holds the switch off with a strong pull-down until both rails report power good. It then soft-starts the gate with a small current source until a second comparator reports the pin near the supply, and finally clamps the pin high with a strong pull-up. The analog comparators, drivers and thresholds sit outside the block. The block receives comparator results and supply and rail status flags, and returns one drive command for the pin.

Top module: `mode_strap_seq`

## Requirements
- R1: While reset is applied and directly after it, the pin command is high impedance, and both `mode_valid` and `two_phase` are 0.
- R2: Arming requires `vin_ok`, `vcc_ok` and at least one of `en_a`/`en_b`, seen through SYNC_STAGES input flops. The first clock edge that sees arming starts a hold-off of DLY_CYC cycles, during which the pin stays high impedance.
- R3: After the hold-off, `pin_weak_dn` is asserted for exactly WIN_CYC consecutive cycles, and no other pin command is active during that time.
- R4: If `sense_gt_lo` is 1 at the window's closing edge, `mode_valid`=1, `two_phase`=0 and the pin goes to high impedance.
- R5: If `sense_gt_lo` is 0 at the window's closing edge, `mode_valid`=1, `two_phase`=1 and the pin goes to `pin_strong_dn`.
- R6: In two-phase mode, `pin_soft_src` is asserted only after both `pg_a` and `pg_b` are 1. Any other combination of the two keeps `pin_strong_dn`.
- R7: During soft-on, `sense_gt_hi`=1 moves the pin to `pin_strong_up` one edge after it is seen.
- R8: If either power-good flag drops during soft-on or strong pull-up, the pin returns to `pin_strong_dn`. The soft-on sequence then starts again when both flags return.
- R9: Once a mode is held, enable changes (including both enables low) have no effect on `mode_valid`, `two_phase` or the pin command.
- R10: Loss of `vin_ok` or `vcc_ok` clears `mode_valid` and `two_phase` and returns the pin to high impedance. The next arming runs a fresh detection.
- R11: If both enables go low during the hold-off or the window, detection is abandoned: the pin returns to high impedance and no mode is reported.
- R12: Exactly one of the five pin command outputs is active in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_ok | input | 1 | Power-stage input supply above its lockout threshold |
| vcc_ok | input | 1 | Controller supply above its lockout threshold |
| en_a | input | 1 | Enable of rail A |
| en_b | input | 1 | Enable of rail B |
| pg_a | input | 1 | Rail A power good |
| pg_b | input | 1 | Rail B power good |
| sense_gt_lo | input | 1 | Pin above supply minus the strap threshold (0.5 V) |
| sense_gt_hi | input | 1 | Pin above supply minus the soft-on completion threshold (0.2 V) |
| mode_valid | output | 1 | A mode has been detected and is held |
| two_phase | output | 1 | 1 = two-phase mode, 0 = dual-channel mode |
| pin_weak_dn | output | 1 | Apply the weak detection pull-down |
| pin_strong_dn | output | 1 | Apply the strong pull-down (switch off) |
| pin_soft_src | output | 1 | Source the small soft-on current |
| pin_strong_up | output | 1 | Apply the strong pull-up (switch fully on) |
| pin_hiz | output | 1 | Leave the pin undriven |

## Verification
The bound checker checks four things on every cycle. Exactly one pin command is active. Soft-on and strong pull-up appear only after both synchronised power-good flags were seen high. A held mode never flips its phase flag. Every completed window lasts exactly WIN_CYC cycles, counted in the checker. Only the bench scenarios can show the hold-off length from an arming edge and the decision taken from the comparator at the window's close. They also cover the abort on lost enables, the indifference to enables once a mode is held, and a fresh detection after a supply drop.

// File: rtl/mode_strap_pkg.sv
package mode_strap_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_HOLDOFF = 3'd1,
      ST_WINDOW  = 3'd2,
      ST_DUAL    = 3'd3,
      ST_TP_OFF  = 3'd4,
      ST_TP_SOFT = 3'd5,
      ST_TP_ON   = 3'd6
   } strap_state_e;

   typedef struct packed {
      logic weak_dn;
      logic strong_dn;
      logic soft_src;
      logic strong_up;
      logic hiz;
   } pin_cmd_t;

   typedef struct packed {
      logic valid;
      logic two_phase;
   } mode_t;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("strap_sync: WIDTH must be at least 1");
   end
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("strap_sync: STAGES must lie in 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_out = d_in;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) begin
               chain_q[s] <= chain_q[s-1];
            end
         end
      end

      assign q_out = chain_q[STAGES-1];
   end

endmodule

// File: rtl/strap_timer.sv
module strap_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [CNT_W-1:0] last_val,
   output logic             at_last
);

   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("strap_timer: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (cnt_q != last_val) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign at_last = (cnt_q == last_val);

endmodule

// File: rtl/strap_pin_decode.sv
module strap_pin_decode
   import mode_strap_pkg::*;
(
   input  strap_state_e state,
   output pin_cmd_t     pin_cmd,
   output mode_t        mode
);

   always_comb begin
      pin_cmd = '0;
      mode    = '0;
      unique case (state)
         ST_HOLDOFF: pin_cmd.hiz = 1'b1;
         ST_WINDOW:  pin_cmd.weak_dn = 1'b1;
         ST_DUAL: begin
            pin_cmd.hiz = 1'b1;
            mode.valid  = 1'b1;
         end
         ST_TP_OFF: begin
            pin_cmd.strong_dn = 1'b1;
            mode.valid        = 1'b1;
            mode.two_phase    = 1'b1;
         end
         ST_TP_SOFT: begin
            pin_cmd.soft_src = 1'b1;
            mode.valid       = 1'b1;
            mode.two_phase   = 1'b1;
         end
         ST_TP_ON: begin
            pin_cmd.strong_up = 1'b1;
            mode.valid        = 1'b1;
            mode.two_phase    = 1'b1;
         end
         default: pin_cmd.hiz = 1'b1;
      endcase
   end

endmodule

// File: rtl/mode_strap_seq.sv
module mode_strap_seq
   import mode_strap_pkg::*;
#(
   parameter int DLY_CYC     = 700,
   parameter int WIN_CYC     = 10600,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vin_ok,
   input  logic vcc_ok,
   input  logic en_a,
   input  logic en_b,
   input  logic pg_a,
   input  logic pg_b,
   input  logic sense_gt_lo,
   input  logic sense_gt_hi,
   output logic mode_valid,
   output logic two_phase,
   output logic pin_weak_dn,
   output logic pin_strong_dn,
   output logic pin_soft_src,
   output logic pin_strong_up,
   output logic pin_hiz
);

   localparam int MAX_CYC = (DLY_CYC > WIN_CYC) ? DLY_CYC : WIN_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam int N_IN    = 8;
   localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY_CYC - 1);
   localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_CYC - 1);

   if (DLY_CYC < 1) begin : g_bad_dly
      $error("mode_strap_seq: DLY_CYC must be at least 1");
   end
   if (WIN_CYC < 1) begin : g_bad_win
      $error("mode_strap_seq: WIN_CYC must be at least 1");
   end

   // synchronised inputs
   logic [N_IN-1:0] raw_in, syn_in;
   logic vin_s, vcc_s, en_a_s, en_b_s, pg_a_s, pg_b_s, lo_s, hi_s;

   assign raw_in = {vin_ok, vcc_ok, en_a, en_b, pg_a, pg_b, sense_gt_lo, sense_gt_hi};

   strap_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_in),
      .q_out (syn_in)
   );

   assign {vin_s, vcc_s, en_a_s, en_b_s, pg_a_s, pg_b_s, lo_s, hi_s} = syn_in;

   logic supply_ok_s, any_en_s, pg_both_s;
   assign supply_ok_s = vin_s & vcc_s;
   assign any_en_s    = en_a_s | en_b_s;
   assign pg_both_s   = pg_a_s & pg_b_s;

   // sequencing state
   strap_state_e state_q, state_d;
   logic         tmr_last, tmr_clr;
   logic [CNT_W-1:0] tmr_limit;

   assign tmr_limit = (state_q == ST_WINDOW) ? WIN_LAST : DLY_LAST;
   assign tmr_clr   = (state_d != state_q) ||
                      !((state_q == ST_HOLDOFF) || (state_q == ST_WINDOW));

   strap_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (tmr_clr),
      .last_val (tmr_limit),
      .at_last  (tmr_last)
   );

   always_comb begin
      state_d = state_q;
      if (!supply_ok_s) begin
         state_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (any_en_s) state_d = ST_HOLDOFF;
            end
            ST_HOLDOFF: begin
               if (!any_en_s)     state_d = ST_IDLE;
               else if (tmr_last) state_d = ST_WINDOW;
            end
            ST_WINDOW: begin
               if (!any_en_s)     state_d = ST_IDLE;
               else if (tmr_last) state_d = lo_s ? ST_DUAL : ST_TP_OFF;
            end
            ST_DUAL: state_d = ST_DUAL;
            ST_TP_OFF: begin
               if (pg_both_s) state_d = ST_TP_SOFT;
            end
            ST_TP_SOFT: begin
               if (!pg_both_s) state_d = ST_TP_OFF;
               else if (hi_s)  state_d = ST_TP_ON;
            end
            ST_TP_ON: begin
               if (!pg_both_s) state_d = ST_TP_OFF;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // output decode
   pin_cmd_t pin_cmd;
   mode_t    mode;

   strap_pin_decode i_decode (
      .state   (state_q),
      .pin_cmd (pin_cmd),
      .mode    (mode)
   );

   assign mode_valid    = mode.valid;
   assign two_phase     = mode.two_phase;
   assign pin_weak_dn   = pin_cmd.weak_dn;
   assign pin_strong_dn = pin_cmd.strong_dn;
   assign pin_soft_src  = pin_cmd.soft_src;
   assign pin_strong_up = pin_cmd.strong_up;
   assign pin_hiz       = pin_cmd.hiz;

endmodule

// File: rtl/mode_strap_seq_chk.sv
module mode_strap_seq_chk #(
   parameter int WIN_CYC = 10600
) (
   input logic clk,
   input logic rst_n,
   input logic supply_ok_s,
   input logic pg_both_s,
   input logic mode_valid,
   input logic two_phase,
   input logic pin_weak_dn,
   input logic pin_strong_dn,
   input logic pin_soft_src,
   input logic pin_strong_up,
   input logic pin_hiz
);

   localparam int RUN_W = $clog2(WIN_CYC + 2);

   logic [RUN_W-1:0] win_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   win_run <= '0;
      else if (!pin_weak_dn)                        win_run <= '0;
      else if (win_run != RUN_W'(WIN_CYC + 1))      win_run <= win_run + 1'b1;
   end

   // R12
   one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({pin_weak_dn, pin_strong_dn, pin_soft_src, pin_strong_up, pin_hiz}) == 1);

   // R3
   win_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_weak_dn |-> (win_run < RUN_W'(WIN_CYC)));

   // R3
   win_len_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pin_weak_dn) && mode_valid) |-> (win_run == RUN_W'(WIN_CYC)));

   // R3
   win_no_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_weak_dn |-> !mode_valid);

   // R4
   dual_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_valid && !two_phase) |-> pin_hiz);

   // R6
   soft_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_soft_src |-> ($past(pg_both_s) && two_phase));

   // R8
   up_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_strong_up |-> ($past(pg_both_s) && two_phase));

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_valid && $past(mode_valid)) |-> $stable(two_phase));

   // R10
   supply_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok_s |=> !mode_valid);

   // R5
   tp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      two_phase |-> mode_valid);

endmodule

bind mode_strap_seq mode_strap_seq_chk #(.WIN_CYC(WIN_CYC)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .supply_ok_s   (supply_ok_s),
   .pg_both_s     (pg_both_s),
   .mode_valid    (mode_valid),
   .two_phase     (two_phase),
   .pin_weak_dn   (pin_weak_dn),
   .pin_strong_dn (pin_strong_dn),
   .pin_soft_src  (pin_soft_src),
   .pin_strong_up (pin_strong_up),
   .pin_hiz       (pin_hiz)
);

// File: tb/test_mode_strap_seq.sv
module test_mode_strap_seq;

   localparam int S   = 2;
   localparam int DLY = 4;
   localparam int WIN = 6;
   localparam int T_WIN = S + 1 + DLY;
   localparam int T_END = T_WIN + WIN;

   // pin vector order {weak, strong_dn, soft_src, strong_up, hiz}
   localparam logic [4:0] P_WEAK = 5'b10000;
   localparam logic [4:0] P_SDN  = 5'b01000;
   localparam logic [4:0] P_SRC  = 5'b00100;
   localparam logic [4:0] P_UP   = 5'b00010;
   localparam logic [4:0] P_HIZ  = 5'b00001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vin_ok = 0, vcc_ok = 0, en_a = 0, en_b = 0, pg_a = 0, pg_b = 0;
   logic sense_gt_lo = 0, sense_gt_hi = 0;
   logic mode_valid, two_phase;
   logic pin_weak_dn, pin_strong_dn, pin_soft_src, pin_strong_up, pin_hiz;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   mode_strap_seq #(.DLY_CYC(DLY), .WIN_CYC(WIN), .SYNC_STAGES(S)) i_mode_strap_seq (
      .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .vcc_ok(vcc_ok),
      .en_a(en_a), .en_b(en_b), .pg_a(pg_a), .pg_b(pg_b),
      .sense_gt_lo(sense_gt_lo), .sense_gt_hi(sense_gt_hi),
      .mode_valid(mode_valid), .two_phase(two_phase),
      .pin_weak_dn(pin_weak_dn), .pin_strong_dn(pin_strong_dn),
      .pin_soft_src(pin_soft_src), .pin_strong_up(pin_strong_up), .pin_hiz(pin_hiz)
   );

   function automatic logic [6:0] obs();
      return {mode_valid, two_phase, pin_weak_dn, pin_strong_dn, pin_soft_src, pin_strong_up, pin_hiz};
   endfunction

   task automatic chk(input string req, input logic [6:0] exp);
      logic [6:0] act = obs();
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // arm and follow one detection cycle by cycle
   task automatic detect(input logic det, input bit use_b);
      sense_gt_lo = det;
      vin_ok = 1; vcc_ok = 1;
      if (use_b) en_b = 1; else en_a = 1;
      for (int n = 1; n <= T_END + 2; n++) begin
         step(1);
         if (n < T_WIN)      chk("R2", {2'b00, P_HIZ});
         else if (n < T_END) chk("R3", {2'b00, P_WEAK});
         else if (det)       chk("R4", {2'b10, P_HIZ});
         else                chk("R5", {2'b11, P_SDN});
      end
   endtask

   task automatic power_down();
      vin_ok = 0; en_a = 0; en_b = 0; pg_a = 0; pg_b = 0; sense_gt_hi = 0;
      step(S + 2);
      chk("R10", {2'b00, P_HIZ});
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000 && !finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      chk("R1", {2'b00, P_HIZ});
      rst_n = 1;
      step(2);
      chk("R1", {2'b00, P_HIZ});

      // only one supply ready: no arming
      vcc_ok = 1; en_a = 1;
      step(S + DLY + 4);
      chk("R2", {2'b00, P_HIZ});
      power_down();

      // dual-channel strap, armed by rail A
      detect(1'b1, 1'b0);
      en_a = 0; step(S + 3);
      chk("R9", {2'b10, P_HIZ});
      power_down();

      // two-phase strap, armed by rail B, power-good sweep
      detect(1'b0, 1'b1);
      for (int c = 0; c < 3; c++) begin
         pg_a = c[0]; pg_b = c[1];
         step(S + 2);
         chk("R6", {2'b11, P_SDN});
      end
      pg_a = 1; pg_b = 1;
      step(S);
      chk("R6", {2'b11, P_SDN});
      step(1);
      chk("R6", {2'b11, P_SRC});
      step(4);
      chk("R6", {2'b11, P_SRC});
      sense_gt_hi = 1;
      step(S + 1);
      chk("R7", {2'b11, P_UP});
      en_a = 0; en_b = 0;
      step(S + 3);
      chk("R9", {2'b11, P_UP});
      pg_a = 0;
      step(S + 1);
      chk("R8", {2'b11, P_SDN});
      sense_gt_hi = 0; pg_a = 1;
      step(S + 1);
      chk("R8", {2'b11, P_SRC});
      pg_b = 0;
      step(S + 1);
      chk("R8", {2'b11, P_SDN});
      pg_b = 1; sense_gt_lo = 1;
      step(S + 1);
      chk("R9", {2'b11, P_SRC});

      // supply loss clears and the next arming reruns detection
      power_down();
      detect(1'b1, 1'b1);
      power_down();

      // enables lost inside the window
      sense_gt_lo = 0; vin_ok = 1; vcc_ok = 1; en_a = 1;
      step(T_WIN + 2);
      chk("R11", {2'b00, P_WEAK});
      en_a = 0;
      step(S + 1);
      chk("R11", {2'b00, P_HIZ});
      step(WIN + 2);
      chk("R11", {2'b00, P_HIZ});

      // enables lost during hold-off
      en_b = 1;
      step(S + 2);
      en_b = 0;
      step(DLY + WIN + S + 2);
      chk("R11", {2'b00, P_HIZ});
      power_down();

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule